// File: doc/BRIEF.md
# Circular Message Queue Manager

This block keeps four circular queues of 32-bit message frame addresses in one contiguous memory region. The queues are inbound free, inbound post, outbound free and outbound post. They sit back to back from a single base address, and each queue occupies one size unit. The block holds the region base, a control register with an enable bit and a size code, and a head and tail pointer for every queue. It reaches the memory region through a single-request memory interface with an acknowledge.

A host sees two ports, inbound and outbound. A read of a port takes the oldest entry from one queue, and a write appends an entry to another queue. Each access makes one memory request, and the port answers only after the memory acknowledges.

The local processor reaches the configuration space through a register port. There it sets the base and the control register, rewrites any pointer after it has handled entries itself, and clears the sticky overflow flags. Two level outputs tell the local side that a post queue holds entries. Two more levels show the overflow flags.

Top module: `msgq_mgr`

## Requirements
- R1: A write to the base register (select 0) is accepted only when bits 19:0 of the data are zero; otherwise the base keeps its previous value.
- R2: An accepted base write reinitialises the queues. Queue k (0 inbound free, 1 inbound post, 2 outbound free, 3 outbound post) starts at base + k × (size code << 11), and both of its pointers are set to that start.
- R3: Control register (select 1) bit 0 is the enable and bits 4:1 are the size code. While the enable is 0, port reads return 0xFFFFFFFF, port writes are dropped and no memory request is made.
- R4: A pop reads memory at the queue's tail and then advances the tail by 4. A push writes memory at the queue's head and then advances the head by 4.
- R5: A pointer that advances onto the start of the following queue wraps to its own queue's start.
- R6: A port read from an empty queue (head equal to tail) returns 0xFFFFFFFF and makes no memory request.
- R7: Port select 0 is the inbound port and 1 is the outbound port. An inbound read pops inbound free and an inbound write pushes inbound post. An outbound read pops outbound post and an outbound write pushes outbound free.
- R8: A push whose advanced head would equal the tail is refused: no memory write takes place, the head does not move and the port answers with data 0. This sets a sticky flag, status bit 0 for inbound post or status bit 1 for outbound free (status is select 2). Writing 1 to a flag's bit clears it.
- R9: `inpost_pending` is high while inbound post is not empty, and `outpost_pending` is high while outbound post is not empty. Each follows the pointers within two cycles.
- R10: At most one memory request is outstanding at a time. Its address, direction and data stay stable until `mem_ack`, and the port acknowledges only after the memory does.
- R11: Register selects 4 to 11 read and write the pointers. Select 4 + 2k is queue k's head and select 5 + 2k is queue k's tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data of the selected register |
| host_req | input | 1 | Port access request, held until host_ack |
| host_port | input | 1 | 0 inbound port, 1 outbound port |
| host_wr | input | 1 | 1 write (push), 0 read (pop) |
| host_wdata | input | 32 | Entry to push |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 32 | Popped entry, 0xFFFFFFFF if none, 0 on writes |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| inpost_pending | output | 1 | Inbound post queue not empty |
| outpost_pending | output | 1 | Outbound post queue not empty |
| inpost_ovf | output | 1 | Sticky inbound post overflow flag |
| outfree_ovf | output | 1 | Sticky outbound free overflow flag |

## Verification
The table-driven pass mixes reads and writes on both ports. Inbound free and outbound post are preloaded by pointer writes, so a returned value shows which queue and which slot a read came from. Reads past the preloaded entries distinguish an empty return from a stale memory read, and a count of memory requests shows that empty pops never reach memory. The directed tests first make the enable bit decide between a dropped access and a real one. They then position pointers one slot short of the tail to isolate the refused push and its flag. A head placed on the last slot of its queue exposes the wrap.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int NQ = 4;

  // queue order fixes the layout inside the region
  typedef enum logic [1:0] {
    Q_IN_FREE  = 2'd0,
    Q_IN_POST  = 2'd1,
    Q_OUT_FREE = 2'd2,
    Q_OUT_POST = 2'd3
  } qid_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RESP = 2'd2
  } port_st_e;

  localparam logic [3:0] SEL_BASE   = 4'd0;
  localparam logic [3:0] SEL_CTRL   = 4'd1;
  localparam logic [3:0] SEL_STATUS = 4'd2;
  localparam logic [3:0] SEL_PTR_LO = 4'd4;
  localparam logic [3:0] SEL_PTR_HI = 4'd11;
endpackage

// File: rtl/msgq_ptr_bank.sv
module msgq_ptr_bank
  import msgq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SZW        = 4,
  parameter int UNIT_SHIFT = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          base,
  input  logic [SZW-1:0]         size_code,
  input  logic                   init,
  input  logic                   lw_en,
  input  logic                   lw_head,
  input  logic [1:0]             lw_q,
  input  logic [AW-1:0]          lw_data,
  input  logic [NQ-1:0]          adv_head,
  input  logic [NQ-1:0]          adv_tail,
  output logic [NQ-1:0][AW-1:0]  heads,
  output logic [NQ-1:0][AW-1:0]  tails,
  output logic [NQ-1:0][AW-1:0]  head_nxt
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] qsize;
  assign qsize = AW'(size_code) << UNIT_SHIFT;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic [AW-1:0] start, limit, tail_nxt, head_inc, tail_inc;
    logic          lw_hit_h, lw_hit_t;

    assign start    = base + AW'(q) * qsize;
    assign limit    = start + qsize;
    assign head_inc = heads[q] + STEP;
    assign tail_inc = tails[q] + STEP;
    assign head_nxt[q] = (head_inc == limit) ? start : head_inc;
    assign tail_nxt    = (tail_inc == limit) ? start : tail_inc;
    assign lw_hit_h = lw_en &&  lw_head && (lw_q == 2'(q));
    assign lw_hit_t = lw_en && !lw_head && (lw_q == 2'(q));

    always_ff @(posedge clk) begin
      if (rst) begin
        heads[q] <= '0;
        tails[q] <= '0;
      end else if (init) begin
        heads[q] <= start;
        tails[q] <= start;
      end else begin
        if (lw_hit_h)         heads[q] <= lw_data;
        else if (adv_head[q]) heads[q] <= head_nxt[q];
        if (lw_hit_t)         tails[q] <= lw_data;
        else if (adv_tail[q]) tails[q] <= tail_nxt;
      end
    end

    // R2: configuration places both pointers on the queue start
    p_init_start_r2: assert property (@(posedge clk) disable iff (rst)
      init |=> (heads[q] == start) && (tails[q] == start));

    // R5: an advancing head moves one entry or wraps to the start
    p_head_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (adv_head[q] && !init && !lw_hit_h) |=>
        ((heads[q] == $past(heads[q]) + STEP) || (heads[q] == start)));

    p_tail_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (adv_tail[q] && !init && !lw_hit_t) |=>
        ((tails[q] == $past(tails[q]) + STEP) || (tails[q] == start)));
  end
endmodule

// File: rtl/msgq_cfg.sv
module msgq_cfg
  import msgq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SZW       = 4,
  parameter int ALIGN_LSB = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [3:0]            cfg_sel,
  input  logic [AW-1:0]         cfg_wdata,
  input  logic [NQ-1:0][AW-1:0] heads,
  input  logic [NQ-1:0][AW-1:0] tails,
  input  logic                  ovf_ip,
  input  logic                  ovf_of,
  output logic [AW-1:0]         base_q,
  output logic                  en_q,
  output logic [SZW-1:0]        size_q,
  output logic                  init_q,
  output logic                  lw_en,
  output logic                  lw_head,
  output logic [1:0]            lw_q,
  output logic                  flag_ip,
  output logic                  flag_of,
  output logic [AW-1:0]         cfg_rdata
);
  logic       base_ok, sel_ptr, clr_ip, clr_of;
  logic [3:0] ptr_idx;

  assign base_ok = (cfg_wdata[ALIGN_LSB-1:0] == '0);
  assign sel_ptr = (cfg_sel >= SEL_PTR_LO) && (cfg_sel <= SEL_PTR_HI);
  assign ptr_idx = cfg_sel - SEL_PTR_LO;
  assign lw_en   = cfg_we && sel_ptr;
  assign lw_head = !ptr_idx[0];
  assign lw_q    = ptr_idx[2:1];
  assign clr_ip  = cfg_we && (cfg_sel == SEL_STATUS) && cfg_wdata[0];
  assign clr_of  = cfg_we && (cfg_sel == SEL_STATUS) && cfg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      en_q    <= 1'b0;
      size_q  <= '0;
      init_q  <= 1'b0;
      flag_ip <= 1'b0;
      flag_of <= 1'b0;
    end else begin
      init_q <= 1'b0;
      if (cfg_we && (cfg_sel == SEL_BASE) && base_ok) begin
        base_q <= cfg_wdata;
        init_q <= 1'b1;
      end
      if (cfg_we && (cfg_sel == SEL_CTRL)) begin
        en_q   <= cfg_wdata[0];
        size_q <= cfg_wdata[SZW:1];
      end
      if (ovf_ip)      flag_ip <= 1'b1;
      else if (clr_ip) flag_ip <= 1'b0;
      if (ovf_of)      flag_of <= 1'b1;
      else if (clr_of) flag_of <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (sel_ptr) begin
      cfg_rdata <= lw_head ? heads[lw_q] : tails[lw_q];
    end else begin
      case (cfg_sel)
        SEL_BASE:   cfg_rdata <= base_q;
        SEL_CTRL:   cfg_rdata <= AW'({size_q, en_q});
        SEL_STATUS: cfg_rdata <= AW'({flag_of, flag_ip});
        default:    cfg_rdata <= '0;
      endcase
    end
  end

  // R1: the held base always sits on an aligned boundary
  p_base_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    base_q[ALIGN_LSB-1:0] == '0);

  // R8: overflow flags stay set until a one is written to them
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_ip && !clr_ip) |=> flag_ip);

  p_flag_sticky_of_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_of && !clr_of) |=> flag_of);
endmodule

// File: rtl/msgq_port_fsm.sv
module msgq_port_fsm
  import msgq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  host_req,
  input  logic                  host_port,
  input  logic                  host_wr,
  input  logic [DW-1:0]         host_wdata,
  input  logic [NQ-1:0][AW-1:0] heads,
  input  logic [NQ-1:0][AW-1:0] tails,
  input  logic [NQ-1:0][AW-1:0] head_nxt,
  input  logic                  mem_ack,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  host_ack,
  output logic [DW-1:0]         host_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  output logic [NQ-1:0]         adv_head,
  output logic [NQ-1:0]         adv_tail,
  output logic                  ovf_ip,
  output logic                  ovf_of
);
  localparam logic [DW-1:0] EMPTY_WORD = '1;

  port_st_e st;
  qid_e     req_q, cur_q;
  logic     cur_push, req_empty, req_full;

  always_comb begin
    if (host_port) req_q = host_wr ? Q_OUT_FREE : Q_OUT_POST;
    else           req_q = host_wr ? Q_IN_POST  : Q_IN_FREE;
  end
  assign req_empty = (heads[req_q] == tails[req_q]);
  assign req_full  = (head_nxt[req_q] == tails[req_q]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur_q      <= Q_IN_FREE;
      cur_push   <= 1'b0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      adv_head   <= '0;
      adv_tail   <= '0;
      ovf_ip     <= 1'b0;
      ovf_of     <= 1'b0;
    end else begin
      host_ack <= 1'b0;
      adv_head <= '0;
      adv_tail <= '0;
      ovf_ip   <= 1'b0;
      ovf_of   <= 1'b0;
      case (st)
        ST_IDLE: if (host_req) begin
          cur_q    <= req_q;
          cur_push <= host_wr;
          if (!en) begin
            host_rdata <= host_wr ? '0 : EMPTY_WORD;
            host_ack   <= 1'b1;
            st         <= ST_RESP;
          end else if (host_wr && req_full) begin
            ovf_ip     <= (req_q == Q_IN_POST);
            ovf_of     <= (req_q == Q_OUT_FREE);
            host_rdata <= '0;
            host_ack   <= 1'b1;
            st         <= ST_RESP;
          end else if (!host_wr && req_empty) begin
            host_rdata <= EMPTY_WORD;
            host_ack   <= 1'b1;
            st         <= ST_RESP;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= host_wr;
            mem_addr  <= host_wr ? heads[req_q] : tails[req_q];
            mem_wdata <= host_wdata;
            st        <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ack) begin
          mem_req    <= 1'b0;
          mem_we     <= 1'b0;
          host_rdata <= cur_push ? '0 : mem_rdata;
          host_ack   <= 1'b1;
          if (cur_push) adv_head[cur_q] <= 1'b1;
          else          adv_tail[cur_q] <= 1'b1;
          st <= ST_RESP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: a pending request holds its address and direction
  p_req_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10: no port answer while memory has not yet answered
  p_ack_waits_mem_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MEM && !mem_ack) |=> !host_ack);

  // R3: a request is only raised while the queues are enabled
  p_no_req_disabled_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(en));

  // R8: a refused push never advances a head in the same response
  p_refuse_no_adv_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_ip || ovf_of) |-> (adv_head == '0));
endmodule

// File: rtl/msgq_mgr.sv
module msgq_mgr
  import msgq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SZW        = 4,
  parameter int UNIT_SHIFT = 11,
  parameter int ALIGN_LSB  = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          host_req,
  input  logic          host_port,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          inpost_pending,
  output logic          outpost_pending,
  output logic          inpost_ovf,
  output logic          outfree_ovf
);
  logic [NQ-1:0][AW-1:0] heads, tails, head_nxt;
  logic [AW-1:0]         base_q;
  logic [SZW-1:0]        size_q;
  logic                  en_q, init_q, lw_en, lw_head, ovf_ip, ovf_of;
  logic [1:0]            lw_q;
  logic [NQ-1:0]         adv_head, adv_tail;

  msgq_cfg #(.AW(AW), .SZW(SZW), .ALIGN_LSB(ALIGN_LSB)) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .heads(heads), .tails(tails),
    .ovf_ip(ovf_ip), .ovf_of(ovf_of), .base_q(base_q), .en_q(en_q),
    .size_q(size_q), .init_q(init_q), .lw_en(lw_en), .lw_head(lw_head),
    .lw_q(lw_q), .flag_ip(inpost_ovf), .flag_of(outfree_ovf),
    .cfg_rdata(cfg_rdata)
  );

  msgq_ptr_bank #(.AW(AW), .SZW(SZW), .UNIT_SHIFT(UNIT_SHIFT)) bank_i (
    .clk(clk), .rst(rst), .base(base_q), .size_code(size_q),
    .init(init_q), .lw_en(lw_en), .lw_head(lw_head), .lw_q(lw_q),
    .lw_data(cfg_wdata), .adv_head(adv_head), .adv_tail(adv_tail),
    .heads(heads), .tails(tails), .head_nxt(head_nxt)
  );

  msgq_port_fsm #(.AW(AW), .DW(DW)) fsm_i (
    .clk(clk), .rst(rst), .en(en_q), .host_req(host_req),
    .host_port(host_port), .host_wr(host_wr), .host_wdata(host_wdata),
    .heads(heads), .tails(tails), .head_nxt(head_nxt),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .adv_head(adv_head),
    .adv_tail(adv_tail), .ovf_ip(ovf_ip), .ovf_of(ovf_of)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inpost_pending  <= 1'b0;
      outpost_pending <= 1'b0;
    end else begin
      inpost_pending  <= (heads[Q_IN_POST]  != tails[Q_IN_POST]);
      outpost_pending <= (heads[Q_OUT_POST] != tails[Q_OUT_POST]);
    end
  end

  // R9: an empty inbound post queue held for two cycles shows no pending level
  p_pending_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (heads[Q_IN_POST] == tails[Q_IN_POST]) && $stable(heads[Q_IN_POST]) &&
    $stable(tails[Q_IN_POST]) |=> !inpost_pending);
endmodule

// File: tb/msgq_mgr_tb.sv
module msgq_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE  = 32'h0010_0000;
  localparam logic [31:0] S_IF  = 32'h0010_0000;
  localparam logic [31:0] S_IP  = 32'h0010_0800;
  localparam logic [31:0] S_OF  = 32'h0010_1000;
  localparam logic [31:0] S_OP  = 32'h0010_1800;
  localparam logic [31:0] NONE  = 32'hFFFF_FFFF;
  // {port, wr, wdata, expected rdata}
  localparam logic [65:0] VEC [8] = '{
    {1'b0, 1'b0, 32'h0, 32'h1111_0000},
    {1'b0, 1'b0, 32'h0, 32'h2222_0000},
    {1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF},
    {1'b0, 1'b1, 32'h0000_00A1, 32'h0},
    {1'b1, 1'b1, 32'h0000_00B1, 32'h0},
    {1'b1, 1'b0, 32'h0, 32'h3333_0000},
    {1'b1, 1'b0, 32'h0, 32'hFFFF_FFFF},
    {1'b0, 1'b1, 32'h0000_00A2, 32'h0}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_we = 1'b0, host_req = 1'b0, host_port = 1'b0, host_wr = 1'b0;
  logic [3:0]  cfg_sel = 4'd0;
  logic [31:0] cfg_wdata = '0, host_wdata = '0;
  logic [31:0] cfg_rdata, host_rdata, mem_addr, mem_wdata;
  logic        host_ack, mem_req, mem_we;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        inpost_pending, outpost_pending, inpost_ovf, outfree_ovf;

  int checks = 0, fails = 0, cyc = 0, nreq = 0;
  logic [31:0] mem [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  msgq_mgr dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_req(host_req),
    .host_port(host_port), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .inpost_pending(inpost_pending), .outpost_pending(outpost_pending),
    .inpost_ovf(inpost_ovf), .outfree_ovf(outfree_ovf)
  );

  // memory model: acknowledges each request one cycle after it appears
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      nreq    <= nreq + 1;
      if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[12:2]];
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not complete, act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [3:0] sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic host_op(input logic port, input logic wr, input logic [31:0] wd,
                         output logic [31:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_port = port; host_wr = wr; host_wdata = wd;
    forever begin
      @(negedge clk);
      if (host_ack) break;
    end
    rd = host_rdata;
    host_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int n0;
    for (int i = 0; i < 2048; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R10 reset host_ack", 32'(host_ack), 32'h0);
    check("R10 reset mem_req", 32'(mem_req), 32'h0);
    check("R9 reset inpost_pending", 32'(inpost_pending), 32'h0);
    rd_reg(4'd0, v);  check("R1 reset base", v, 32'h0);

    // R1 aligned base accepted, unaligned rejected
    wr_reg(4'd1, 32'h0000_0002);             // size code 1, disabled
    wr_reg(4'd0, BASE);
    rd_reg(4'd0, v);  check("R1 aligned base accepted", v, BASE);
    wr_reg(4'd0, 32'h0018_0400);
    rd_reg(4'd0, v);  check("R1 unaligned base rejected", v, BASE);

    // R2 layout and pointer initialisation, R11 pointer readback
    rd_reg(4'd4, v);  check("R2 inbound free head", v, S_IF);
    rd_reg(4'd7, v);  check("R2 inbound post tail", v, S_IP);
    rd_reg(4'd8, v);  check("R2 outbound free head", v, S_OF);
    rd_reg(4'd11, v); check("R2 outbound post tail", v, S_OP);

    // R3 disabled: reads all ones, writes dropped, no memory traffic
    n0 = nreq;
    host_op(1'b0, 1'b0, 32'h0, v); check("R3 disabled read", v, NONE);
    host_op(1'b0, 1'b1, 32'h55, v);
    rd_reg(4'd6, v);  check("R3 disabled write dropped", v, S_IP);
    check("R3 no memory request while disabled", 32'(nreq - n0), 32'h0);
    wr_reg(4'd1, 32'h0000_0003);
    rd_reg(4'd1, v);  check("R3 control readback", v, 32'h3);

    // preload: two entries in inbound free, one in outbound post (R11)
    mem[S_IF[12:2]]       = 32'h1111_0000;
    mem[S_IF[12:2] + 1]   = 32'h2222_0000;
    mem[S_OP[12:2]]       = 32'h3333_0000;
    wr_reg(4'd4, S_IF + 32'd8);
    wr_reg(4'd10, S_OP + 32'd4);
    check("R9 outpost pending after preload", 32'(outpost_pending), 32'h1);

    // table walk (R4, R6, R7)
    n0 = nreq;
    for (int k = 0; k < 8; k++) begin
      host_op(VEC[k][65], VEC[k][64], VEC[k][63:32], v);
      check($sformatf("R7 vector %0d", k), v, VEC[k][31:0]);
    end
    check("R6 empty pops make no request", 32'(nreq - n0), 32'd6);
    check("R4 push A1 at inbound post head", mem[S_IP[12:2]], 32'hA1);
    check("R4 push A2 next slot", mem[S_IP[12:2] + 1], 32'hA2);
    check("R7 outbound write to outbound free", mem[S_OF[12:2]], 32'hB1);
    rd_reg(4'd6, v);  check("R4 inbound post head advanced", v, S_IP + 32'd8);
    rd_reg(4'd5, v);  check("R4 inbound free tail advanced", v, S_IF + 32'd8);
    check("R9 inpost pending", 32'(inpost_pending), 32'h1);
    check("R9 outpost drained", 32'(outpost_pending), 32'h0);
    wr_reg(4'd7, S_IP + 32'd8);
    @(negedge clk);
    check("R9 inpost cleared by local tail write", 32'(inpost_pending), 32'h0);

    // R8 outbound free overflow
    wr_reg(4'd9, S_OF + 32'd12);
    host_op(1'b1, 1'b1, 32'hB2, v);
    check("R8 push before full", mem[S_OF[12:2] + 1], 32'hB2);
    n0 = nreq;
    host_op(1'b1, 1'b1, 32'hB3, v);
    check("R8 refused push data", v, 32'h0);
    check("R8 refused push no request", 32'(nreq - n0), 32'h0);
    rd_reg(4'd8, v);  check("R8 head held on overflow", v, S_OF + 32'd8);
    check("R8 outfree flag", 32'(outfree_ovf), 32'h1);
    rd_reg(4'd2, v);  check("R8 status bit1", v, 32'h2);

    // R8 inbound post overflow, sticky, then W1C per bit
    wr_reg(4'd7, S_IP + 32'd12);
    host_op(1'b0, 1'b1, 32'hA3, v);
    rd_reg(4'd2, v);  check("R8 both flags set", v, 32'h3);
    wr_reg(4'd2, 32'h2);
    rd_reg(4'd2, v);  check("R8 clear only outfree flag", v, 32'h1);
    wr_reg(4'd2, 32'h1);
    check("R8 inpost flag cleared", 32'(inpost_ovf), 32'h0);

    // R5 wrap of outbound free head from its last slot
    wr_reg(4'd8, S_OF + 32'h7FC);
    wr_reg(4'd9, S_OF + 32'h400);
    host_op(1'b1, 1'b1, 32'hC1, v);
    check("R5 entry in last slot", mem[S_OF[12:2] + 511], 32'hC1);
    rd_reg(4'd8, v);  check("R5 head wrapped to start", v, S_OF);

    // R5 wrap of outbound post tail on pop
    mem[S_OP[12:2] + 511] = 32'h4444_0000;
    wr_reg(4'd11, S_OP + 32'h7FC);
    wr_reg(4'd10, S_OP + 32'h10);
    host_op(1'b1, 1'b0, 32'h0, v);
    check("R5 pop from last slot", v, 32'h4444_0000);
    rd_reg(4'd11, v); check("R5 tail wrapped to start", v, S_OP);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule